// File: doc/BRIEF.md
# Fuse Partition Write-Lock Gate

This block stands between a write requester and a one-time-programmable fuse array that is divided into equal partitions of `WPP` words. Every incoming write names a partition, a word within it and a data word. One cycle later the gate answers with a grant or a denial and a status code. A grant also issues the write strobe, address and data to the array. The decision depends on three things: whether the partition is already sealed, whether the present lifecycle state belongs to the phase in which that partition may be programmed, and whether the write would turn any programmed bit back to zero.

The gate keeps its own image of the array contents, starting from all zeros because unprogrammed bits read as zero. It uses this image to find sealed partitions and to catch writes that would clear bits. The last word of every partition is its digest. Once that word holds a nonzero value, the partition is sealed for good, and the seal state of each partition is visible on `lock_status`. When the device has reached the scrap state, a zeroize command walks through every partition marked as erasable and drives all-ones into each of its words, whether or not the partition is sealed.

Top module: `otp_wlock_gate`

## Requirements
- R1: Out of reset, `resp_valid`, `resp_grant`, `fuse_we`, `zero_busy`, `zero_done` and every `lock_status` bit are 0, and `resp_status` is 0.
- R2: A request presented with `req_valid` during one clock edge is answered after that edge with `resp_valid`=1. A grant carries `resp_status`=0 (OK) and, in the same cycle, `fuse_we`=1 with `fuse_addr`={partition, word} and `fuse_wdata` equal to the request data.
- R3: A partition index of `NPART` or more is denied with status 3 (bad partition). This check takes priority over every other check.
- R4: A partition is sealed when its last word (the digest, word `WPP-1`) is nonzero. Writing a zero digest does not seal it. A sealed partition shows 1 on `lock_status[p]`, and every later write to it is denied with status 1 (locked). Status 1 takes priority over statuses 2 and 4.
- R5: `lc_state` is encoded 0 raw, 1 test-unlocked, 2 test-locked, 3 manuf, 4 prod, 5 prod-end, 6 rma, 7 scrap. The class of each partition (2 bits at `PART_CLASS[2p+:2]`) sets where writes are allowed: class 0 only in state 1, class 1 only in state 3, class 2 in states 3, 4 and 5. Any other state gives status 2 (wrong lifecycle).
- R6: A write that would change a programmed 1 bit to 0 is denied with status 4 (clear attempt), and the array is not written.
- R7: `zero_start` in state 7 sets `zero_busy` for exactly `NPART*WPP` cycles. During that time the block writes all-ones to every word of each partition whose `ZERO_MASK` bit is set, one word per cycle, in ascending address order. After the walk `zero_busy` falls and `zero_done` stays 1. Erased partitions then read as sealed.
- R8: `zero_start` in any state other than 7 is ignored. No write strobe is issued, and `zero_busy` and `zero_done` stay 0.
- R9: No programming request is granted in state 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_state | input | 3 | Current lifecycle state |
| req_valid | input | 1 | Write request present |
| req_part | input | PW+1 | Partition index (may be out of range) |
| req_word | input | WW | Word within the partition |
| req_data | input | DW | Data to program |
| zero_start | input | 1 | Start the erase walk |
| resp_valid | output | 1 | Decision available |
| resp_grant | output | 1 | Request allowed |
| resp_status | output | 3 | 0 ok, 1 locked, 2 wrong lifecycle, 3 bad partition, 4 clear attempt |
| fuse_we | output | 1 | Array write strobe |
| fuse_addr | output | PW+WW | Array word address |
| fuse_wdata | output | DW | Array write data |
| zero_busy | output | 1 | Erase walk in progress |
| zero_done | output | 1 | Erase walk completed |
| lock_status | output | NPART | Seal state of each partition |

## Verification
Some properties are checked on every cycle. A grant always comes with a write strobe and an OK status. A request is always answered on the next cycle. Nothing is granted in scrap. Seal bits never drop. Every erase write carries all-ones. Busy and done are never both set. Other behaviour can only be shown by the bench's scenarios: which lifecycle states open which partition class, the priority order among the denial codes, the clear-attempt check against earlier contents, and the exact address sequence and length of the erase walk. For these the bench sweeps every lifecycle state against every partition and compares with its own model of the array.

// File: rtl/otp_wlock_gate.sv
module otp_wlock_gate #(
  parameter int NPART = 4,
  parameter int WPP = 4,
  parameter int DW = 8,
  parameter logic [2*NPART-1:0] PART_CLASS = 8'b10_10_01_00,
  parameter logic [NPART-1:0] ZERO_MASK = 4'b0110,
  localparam int PW = $clog2(NPART),
  localparam int WW = $clog2(WPP),
  localparam int AW = PW + WW,
  localparam int NW = NPART * WPP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    lc_state,
  input  logic          req_valid,
  input  logic [PW:0]   req_part,
  input  logic [WW-1:0] req_word,
  input  logic [DW-1:0] req_data,
  input  logic          zero_start,
  output logic          resp_valid,
  output logic          resp_grant,
  output logic [2:0]    resp_status,
  output logic          fuse_we,
  output logic [AW-1:0] fuse_addr,
  output logic [DW-1:0] fuse_wdata,
  output logic          zero_busy,
  output logic          zero_done,
  output logic [NPART-1:0] lock_status
);
  localparam logic [2:0] LC_TU = 3'd1, LC_MANUF = 3'd3, LC_PROD = 3'd4,
                         LC_PEND = 3'd5, LC_SCRAP = 3'd7;
  localparam logic [2:0] ST_OK = 3'd0, ST_LOCK = 3'd1, ST_LC = 3'd2,
                         ST_PART = 3'd3, ST_CLR = 3'd4;

  logic [DW-1:0] mem [NW];
  logic [AW-1:0] zptr;

  for (genvar p = 0; p < NPART; p++) begin : g_lock
    assign lock_status[p] = |mem[p*WPP + WPP - 1];
  end

  logic          part_ok, lc_ok, clr, zhit;
  logic [PW-1:0] pidx;
  logic [AW-1:0] addr;
  logic [1:0]    cls;
  logic [2:0]    st;

  assign part_ok = req_part < (PW+1)'(NPART);
  assign pidx    = req_part[PW-1:0];
  assign addr    = {pidx, req_word};
  assign cls     = PART_CLASS[2*pidx +: 2];
  assign clr     = |(mem[addr] & ~req_data);
  assign zhit    = ZERO_MASK[zptr[AW-1:WW]];

  always_comb begin
    case (cls)
      2'd0:    lc_ok = lc_state == LC_TU;
      2'd1:    lc_ok = lc_state == LC_MANUF;
      default: lc_ok = lc_state == LC_MANUF || lc_state == LC_PROD || lc_state == LC_PEND;
    endcase
    if (!part_ok)                   st = ST_PART;
    else if (lock_status[pidx])     st = ST_LOCK;
    else if (!lc_ok || zero_busy)   st = ST_LC;
    else if (clr)                   st = ST_CLR;
    else                            st = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_grant  <= 1'b0;
      resp_status <= ST_OK;
      fuse_we     <= 1'b0;
      fuse_addr   <= '0;
      fuse_wdata  <= '0;
      zero_busy   <= 1'b0;
      zero_done   <= 1'b0;
      zptr        <= '0;
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else begin
      resp_valid  <= req_valid;
      resp_grant  <= req_valid && st == ST_OK;
      resp_status <= req_valid ? st : ST_OK;
      fuse_we     <= 1'b0;
      if (zero_busy) begin
        if (zhit) begin
          fuse_we    <= 1'b1;
          fuse_addr  <= zptr;
          fuse_wdata <= '1;
          mem[zptr]  <= '1;
        end
        if (zptr == AW'(NW-1)) begin
          zero_busy <= 1'b0;
          zero_done <= 1'b1;
        end else begin
          zptr <= zptr + 1'b1;
        end
      end else if (zero_start && lc_state == LC_SCRAP) begin
        zero_busy <= 1'b1;
        zero_done <= 1'b0;
        zptr      <= '0;
      end
      if (req_valid && st == ST_OK) begin
        fuse_we    <= 1'b1;
        fuse_addr  <= addr;
        fuse_wdata <= req_data;
        mem[addr]  <= req_data;
      end
    end
  end

  // R2
  grant_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_grant |-> (fuse_we && resp_valid && resp_status == ST_OK));
  // R2
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  // R9
  scrap_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lc_state == LC_SCRAP) |=> !resp_grant);
  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_status & $past(lock_status)) == $past(lock_status));
  // R7
  zero_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_busy && !req_valid) |=> (!fuse_we || fuse_wdata == '1));
  // R7
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_busy && zero_done));
endmodule

// File: tb/otp_wlock_gate_tb.sv
module otp_wlock_gate_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [2:0] lc_state = 0;
  logic       req_valid = 0, zero_start = 0;
  logic [2:0] req_part = 0;
  logic [1:0] req_word = 0;
  logic [7:0] req_data = 0;
  logic       resp_valid, resp_grant, fuse_we, zero_busy, zero_done;
  logic [2:0] resp_status;
  logic [3:0] fuse_addr, lock_status;
  logic [7:0] fuse_wdata;

  otp_wlock_gate u_dut (.clk, .rst_n, .lc_state, .req_valid, .req_part, .req_word,
    .req_data, .zero_start, .resp_valid, .resp_grant, .resp_status, .fuse_we,
    .fuse_addr, .fuse_wdata, .zero_busy, .zero_done, .lock_status);

  int n_chk = 0, n_bad = 0;
  logic [7:0] bm [16];
  logic [3:0] zaddr [32];
  logic [7:0] zdata [32];
  int zcnt = 0;
  logic collect = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_st(int p, int w, logic [7:0] d, int lc);
    int cls;
    bit ok;
    if (p >= 4) return 3;
    if (bm[p*4+3] != 0) return 1;
    cls = (p == 0) ? 0 : (p == 1) ? 1 : 2;
    ok = (cls == 0) ? (lc == 1) : (cls == 1) ? (lc == 3) : (lc == 3 || lc == 4 || lc == 5);
    if (!ok) return 2;
    if ((bm[p*4+w] & ~d) != 0) return 4;
    return 0;
  endfunction

  function automatic logic [3:0] exp_lock();
    logic [3:0] l;
    for (int p = 0; p < 4; p++) l[p] = bm[p*4+3] != 0;
    return l;
  endfunction

  task automatic do_req(int p, int w, logic [7:0] d, string req);
    int e;
    e = exp_st(p, w, d, int'(lc_state));
    @(negedge clk);
    req_valid = 1; req_part = 3'(p); req_word = 2'(w); req_data = d;
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid && resp_status == 3'(e) && resp_grant == (e == 0), req, int'(resp_status), e);
    if (e == 0) begin
      chk(fuse_we && fuse_addr == 4'(p*4+w) && fuse_wdata == d, req, int'(fuse_addr), p*4+w);
      bm[p*4+w] = d;
    end else begin
      chk(!fuse_we, req, int'(fuse_we), 0);
    end
    chk(lock_status == exp_lock(), "R4", int'(lock_status), int'(exp_lock()));
  endtask

  always @(negedge clk) if (collect && fuse_we && zcnt < 32) begin
    zaddr[zcnt] = fuse_addr; zdata[zcnt] = fuse_wdata; zcnt++;
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int bc;
    for (int i = 0; i < 16; i++) bm[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!resp_valid && !resp_grant && !fuse_we && !zero_busy && !zero_done &&
        lock_status == 0 && resp_status == 0, "R1", int'(resp_status), 0);
    rst_n = 1;
    // R3 out-of-range partitions in every state
    for (int lc = 0; lc < 8; lc++) begin
      lc_state = 3'(lc);
      for (int p = 4; p < 8; p++) do_req(p, 0, 8'h01, "R3");
    end
    // R5 R2 sweep of lifecycle against partition, growing bits then a clearing write (R6)
    for (int lc = 0; lc < 7; lc++) begin
      lc_state = 3'(lc);
      for (int p = 0; p < 4; p++) begin
        do_req(p, 0, bm[p*4] | 8'(1 << lc), "R5");
        if (bm[p*4] != 0) do_req(p, 0, 8'h00, "R6");
      end
    end
    // R6 explicit clear attempt and preserved contents
    lc_state = 3;
    do_req(1, 1, 8'h0F, "R2");
    do_req(1, 1, 8'h0E, "R6");
    do_req(1, 1, 8'h1F, "R6");
    // R4 zero digest leaves open, nonzero digest seals
    do_req(1, 3, 8'h00, "R4");
    do_req(1, 2, 8'h30, "R4");
    do_req(1, 3, 8'h5A, "R4");
    do_req(1, 0, 8'hFF, "R4");
    lc_state = 1;
    do_req(1, 0, 8'hFF, "R4");
    lc_state = 4;
    do_req(3, 3, 8'h80, "R4");
    do_req(3, 1, 8'h01, "R4");
    do_req(2, 1, 8'h22, "R2");
    // R8 erase request outside scrap
    for (int lc = 0; lc < 7; lc++) begin
      lc_state = 3'(lc);
      @(negedge clk); zero_start = 1;
      @(negedge clk); zero_start = 0;
      chk(!zero_busy && !zero_done && !fuse_we, "R8", int'(zero_busy), 0);
    end
    // R9 scrap denies programming
    lc_state = 7;
    do_req(0, 1, 8'h01, "R9");
    do_req(2, 2, 8'h01, "R9");
    // R7 erase walk
    collect = 1;
    @(negedge clk); zero_start = 1;
    @(negedge clk); zero_start = 0;
    bc = 0;
    while (zero_busy && bc < 100) begin bc++; @(negedge clk); end
    collect = 0;
    chk(bc == 16, "R7", bc, 16);
    chk(zero_done && !zero_busy, "R7", int'(zero_done), 1);
    chk(zcnt == 8, "R7", zcnt, 8);
    for (int i = 0; i < 8; i++)
      chk(i < zcnt && zaddr[i] == 4'(4 + i) && zdata[i] == 8'hFF, "R7", int'(zaddr[i]), 4 + i);
    for (int i = 4; i < 12; i++) bm[i] = 8'hFF;
    chk(lock_status == exp_lock(), "R7", int'(lock_status), int'(exp_lock()));
    repeat (3) @(negedge clk);
    chk(zero_done && !fuse_we, "R7", int'(zero_done), 1);
    finish_run();
  end
endmodule